// File: doc/BRIEF.md
# 64-bit Comparator Timer

This block is a free-running 64-bit up-counter paired with a 64-bit compare register. When the comparator is armed and the count equals the compare value, a sticky event flag is set. Software clears the flag by writing a one to it. The interrupt line is the flag gated by an enable bit. An optional periodic mode adds a programmable step to the compare value on every event, so events keep recurring without software reloading the comparator.

Software reaches the block through a word-wide register port with a valid/ready request channel. Every accepted request returns a one-cycle response. The 64-bit quantities are split into 32-bit halves. A carry out of the low counter word reaches the high word on the same edge as the wrap, so a read sequence of high, low, high is always consistent. A compare value can be changed safely by disarming the comparator, writing both halves and re-arming it.

Top module: `cmp_timer`

## Requirements
- R1: After reset the counter, compare value, step, control and event flag are all zero, the counter does not advance, and `irq_o` is low.
- R2: While control bit 0 is set, the counter increases by exactly one on every clock; while it is clear, the counter holds unless software writes it.
- R3: The high counter word increments on the same edge on which the low word wraps from all ones to zero.
- R4: Writes to the counter words (offsets 0x00 low, 0x04 high) take effect only while control bit 0 is clear; while counting they are ignored.
- R5: Registers sit at word offsets: counter low 0x00, counter high 0x04, control 0x08, status 0x0C, compare low 0x10, compare high 0x14, step 0x18.
- R6: While control bit 1 is set, a cycle in which the counter equals the compare value sets status bit 0 on the following edge; while bit 1 is clear, no event is raised.
- R7: Status bit 0 stays set until software writes 1 to it at 0x0C; writing 0 has no effect, and a new event in the same cycle as the clear leaves it set.
- R8: When control bits 1 and 3 are both set, each event adds the 32-bit step register (0x18, zero-extended) to the compare value; a software write to a compare half in that cycle wins.
- R9: `irq_o` is high exactly when status bit 0 and control bit 2 are both set.
- R10: Control reads back bits 3:0 as written, with the upper bits zero; unmapped or unaligned offsets read as zero and writes to them change nothing.
- R11: The request port is always ready; every accepted request yields `rsp_valid_o` on the next cycle, carrying read data sampled at the accepting edge, or zero for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Register request ready (always high) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 5 | Byte offset of the register |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after acceptance |
| rsp_rdata_o | output | 32 | Read data, zero for writes |
| irq_o | output | 1 | Interrupt request |

## Verification
A directed sequence starts the counter three counts below a low-word wrap and reads high, low, high words back to back. This shows whether the carry lands on the wrap edge and whether the counter steps by one. A write to the counter while it runs then tells ignored writes apart from accepted ones. Constrained random traffic places compare values and counter values within a few counts of each other and toggles every control bit. A bench reference model then separates correct event timing, sticky clear semantics, set-over-clear priority, periodic step addition and interrupt gating from off-by-one or lost-event faults. Reads of unmapped and unaligned offsets are mixed in throughout.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned CTRL_W = 4;

  localparam logic [ADDR_W-1:0] OFS_CNT_LO = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_CMP_LO = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_CMP_HI = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_STEP   = 5'h18;

  // field order is the control word bit order, msb first
  typedef struct packed {
    logic step_en;
    logic irq_en;
    logic cmp_en;
    logic cnt_en;
  } ctrl_t;

  typedef struct packed {
    logic cnt_lo;
    logic cnt_hi;
    logic ctrl;
    logic stat;
    logic cmp_lo;
    logic cmp_hi;
    logic step;
  } wr_stb_t;
endpackage

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
  import cmp_timer_pkg::*;
#(
  parameter int unsigned REG_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic                 req_write_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic [REG_W-1:0]     req_wdata_i,
  output logic                 rsp_valid_o,
  output logic [REG_W-1:0]     rsp_rdata_o,
  input  logic [2*REG_W-1:0]   cnt_i,
  input  logic [2*REG_W-1:0]   cmp_i,
  input  logic                 flag_i,
  output wr_stb_t              stb_o,
  output ctrl_t                ctrl_o,
  output logic [REG_W-1:0]     step_o
);
  logic           wr_acc;
  logic [REG_W-1:0] rd_data;
  ctrl_t          ctrl_q;
  logic [REG_W-1:0] step_q;

  assign wr_acc = req_valid_i & req_write_i;

  always_comb begin
    stb_o   = '0;
    rd_data = '0;
    case (req_addr_i)
      OFS_CNT_LO: begin stb_o.cnt_lo = wr_acc; rd_data = cnt_i[REG_W-1:0]; end
      OFS_CNT_HI: begin stb_o.cnt_hi = wr_acc; rd_data = cnt_i[2*REG_W-1:REG_W]; end
      OFS_CTRL:   begin stb_o.ctrl   = wr_acc; rd_data = REG_W'(ctrl_q); end
      OFS_STAT:   begin stb_o.stat   = wr_acc; rd_data = REG_W'(flag_i); end
      OFS_CMP_LO: begin stb_o.cmp_lo = wr_acc; rd_data = cmp_i[REG_W-1:0]; end
      OFS_CMP_HI: begin stb_o.cmp_hi = wr_acc; rd_data = cmp_i[2*REG_W-1:REG_W]; end
      OFS_STEP:   begin stb_o.step   = wr_acc; rd_data = step_q; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= '0;
      step_q      <= '0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      if (stb_o.ctrl) ctrl_q <= ctrl_t'(req_wdata_i[CTRL_W-1:0]);
      if (stb_o.step) step_q <= req_wdata_i;
      rsp_valid_o <= req_valid_i;
      rsp_rdata_o <= (req_valid_i && !req_write_i) ? rd_data : '0;
    end
  end

  assign ctrl_o = ctrl_q;
  assign step_o = step_q;

  assert_rsp_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  assert_rsp_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  assert_ctrl_wr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && req_addr_i == OFS_CTRL)
      |=> ctrl_q == ctrl_t'($past(req_wdata_i[CTRL_W-1:0])));
endmodule

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 wr_lo_i,
  input  logic                 wr_hi_i,
  input  logic [CNT_W/2-1:0]   wdata_i,
  output logic [CNT_W-1:0]     cnt_o
);
  localparam int unsigned HALF = CNT_W / 2;

  logic [CNT_W-1:0] cnt_q;

  // single full-width adder: carry into the high half lands on the wrap edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (en_i) begin
      cnt_q <= cnt_q + 1'b1;
    end else begin
      if (wr_lo_i) cnt_q[HALF-1:0]     <= wdata_i;
      if (wr_hi_i) cnt_q[CNT_W-1:HALF] <= wdata_i;
    end
  end

  assign cnt_o = cnt_q;

  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_q));
  assert_carry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (&cnt_q[HALF-1:0]))
      |=> (cnt_q[HALF-1:0] == '0) && (cnt_q[CNT_W-1:HALF] == $past(cnt_q[CNT_W-1:HALF]) + 1'b1));
  assert_wr_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (wr_lo_i || wr_hi_i)) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/cmp_timer_compare.sv
module cmp_timer_compare #(
  parameter int unsigned CNT_W = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic                 cmp_en_i,
  input  logic                 step_en_i,
  input  logic [CNT_W/2-1:0]   step_i,
  input  logic                 wr_lo_i,
  input  logic                 wr_hi_i,
  input  logic [CNT_W/2-1:0]   wdata_i,
  input  logic                 clr_i,
  output logic [CNT_W-1:0]     cmp_o,
  output logic                 flag_o
);
  localparam int unsigned HALF = CNT_W / 2;

  logic [CNT_W-1:0] cmp_q;
  logic             flag_q;
  logic             hit;

  assign hit = cmp_en_i && (cnt_i == cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_lo_i || wr_hi_i) begin
        if (wr_lo_i) cmp_q[HALF-1:0]     <= wdata_i;
        if (wr_hi_i) cmp_q[CNT_W-1:HALF] <= wdata_i;
      end else if (hit && step_en_i) begin
        cmp_q <= cmp_q + {{HALF{1'b0}}, step_i};
      end
      // a new event outranks a same-cycle clear
      flag_q <= hit | (flag_q & ~clr_i);
    end
  end

  assign cmp_o  = cmp_q;
  assign flag_o = flag_q;

  assert_event_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_en_i && cnt_i == cmp_q) |=> flag_q);
  assert_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmp_en_i && !flag_q) |=> !flag_q);
  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
  assert_step_add_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && step_en_i && !wr_lo_i && !wr_hi_i)
      |=> cmp_q == $past(cmp_q + {{HALF{1'b0}}, step_i}));
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int unsigned REG_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic                 req_write_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic [REG_W-1:0]     req_wdata_i,
  output logic                 rsp_valid_o,
  output logic [REG_W-1:0]     rsp_rdata_o,
  output logic                 irq_o
);
  localparam int unsigned CNT_W = 2 * REG_W;

  wr_stb_t          stb;
  ctrl_t            ctrl;
  logic [REG_W-1:0] step;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmp;
  logic             flag;

  assign req_ready_o = 1'b1;

  cmp_timer_regs #(.REG_W(REG_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o),
    .cnt_i       (cnt),
    .cmp_i       (cmp),
    .flag_i      (flag),
    .stb_o       (stb),
    .ctrl_o      (ctrl),
    .step_o      (step)
  );

  cmp_timer_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (ctrl.cnt_en),
    .wr_lo_i (stb.cnt_lo),
    .wr_hi_i (stb.cnt_hi),
    .wdata_i (req_wdata_i),
    .cnt_o   (cnt)
  );

  cmp_timer_compare #(.CNT_W(CNT_W)) u_compare (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_i     (cnt),
    .cmp_en_i  (ctrl.cmp_en),
    .step_en_i (ctrl.step_en),
    .step_i    (step),
    .wr_lo_i   (stb.cmp_lo),
    .wr_hi_i   (stb.cmp_hi),
    .wdata_i   (req_wdata_i),
    .clr_i     (stb.stat & req_wdata_i[0]),
    .cmp_o     (cmp),
    .flag_o    (flag)
  );

  assign irq_o = flag & ctrl.irq_en;
endmodule

// File: tb/cmp_timer_bench.sv
module cmp_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        write = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        ready, rsp_valid, irq;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  cmp_timer u_cmp_timer (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
    .req_write_i(write), .req_addr_i(addr), .req_wdata_i(wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .irq_o(irq)
  );

  // reference model built from the requirements
  logic [63:0] m_cnt, m_cmp;
  logic [3:0]  m_ctrl;
  logic [31:0] m_step, m_rdata;
  logic        m_flag, m_rsp_v;
  logic [4:0]  m_rsp_addr;

  function automatic logic [31:0] exp_read(input logic [4:0] a);
    case (a)
      5'h00: return m_cnt[31:0];
      5'h04: return m_cnt[63:32];
      5'h08: return {28'd0, m_ctrl};
      5'h0C: return {31'd0, m_flag};
      5'h10: return m_cmp[31:0];
      5'h14: return m_cmp[63:32];
      5'h18: return m_step;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] a);
    case (a)
      5'h00, 5'h04: return "R2 R3 R4 R5 R11";
      5'h08:        return "R10 R5 R11";
      5'h0C:        return "R6 R7 R5 R11";
      5'h10, 5'h14, 5'h18: return "R8 R5 R11";
      default:      return "R10 R11";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = '0; m_cmp = '0; m_ctrl = '0; m_step = '0; m_flag = 1'b0;
      m_rsp_v = 1'b0; m_rdata = '0; m_rsp_addr = '0;
    end else begin
      logic hit, wr;
      logic [63:0] n_cnt, n_cmp;
      hit = m_ctrl[1] && (m_cnt == m_cmp);
      wr  = valid && write;
      m_rsp_v = valid;
      m_rdata = (valid && !write) ? exp_read(addr) : 32'd0;
      m_rsp_addr = addr;
      n_cnt = m_cnt;
      if (m_ctrl[0]) n_cnt = m_cnt + 64'd1;
      else if (wr && addr == 5'h00) n_cnt[31:0] = wdata;
      else if (wr && addr == 5'h04) n_cnt[63:32] = wdata;
      n_cmp = m_cmp;
      if (wr && addr == 5'h10) n_cmp[31:0] = wdata;
      else if (wr && addr == 5'h14) n_cmp[63:32] = wdata;
      else if (hit && m_ctrl[3]) n_cmp = m_cmp + {32'd0, m_step};
      m_flag = hit | (m_flag & !(wr && addr == 5'h0C && wdata[0]));
      if (wr && addr == 5'h08) m_ctrl = wdata[3:0];
      if (wr && addr == 5'h18) m_step = wdata;
      m_cnt = n_cnt;
      m_cmp = n_cmp;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(rsp_valid == m_rsp_v, "R11 rsp_valid", 64'(rsp_valid), 64'(m_rsp_v));
      if (m_rsp_v)
        chk(rsp_rdata == m_rdata, tag_of(m_rsp_addr), 64'(rsp_rdata), 64'(m_rdata));
      chk(irq == (m_flag & m_ctrl[2]), "R9 irq", 64'(irq), 64'(m_flag & m_ctrl[2]));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      checks++;
      $display("FAIL R11 watchdog: actual hang expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    valid = 1'b1; write = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; write = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
    valid = 1'b1; write = 1'b0; addr = a;
    @(negedge clk);
    d = rsp_rdata;
    valid = 1'b0;
  endtask

  initial begin
    logic [31:0] d, h1, l1, h2, l2, h3;
    logic [4:0] addrs [9];
    int unsigned seed;
    addrs = '{5'h00, 5'h04, 5'h08, 5'h0C, 5'h10, 5'h14, 5'h18, 5'h1C, 5'h02};
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, counter stopped
    chk(irq == 1'b0, "R1 irq after reset", 64'(irq), 64'd0);
    rd_reg(5'h08, d); chk(d == 32'd0, "R1 ctrl after reset", 64'(d), 64'd0);
    rd_reg(5'h00, h1); rd_reg(5'h00, h2);
    chk(h1 == 32'd0 && h2 == 32'd0, "R1 counter stopped", {h1, h2}, 64'd0);

    // R2 R3: start three counts below the low-word wrap
    wr_reg(5'h00, 32'hFFFF_FFFD);
    wr_reg(5'h04, 32'd7);
    wr_reg(5'h08, 32'd1);
    rd_reg(5'h04, h1); rd_reg(5'h00, l1); rd_reg(5'h04, h2);
    rd_reg(5'h00, l2); rd_reg(5'h04, h3);
    chk(h1 == 32'd7, "R2 high before wrap", 64'(h1), 64'd7);
    chk(l1 == 32'hFFFF_FFFE, "R2 low steps by one", 64'(l1), 64'hFFFF_FFFE);
    chk(h2 == 32'd7, "R3 high at all-ones low", 64'(h2), 64'd7);
    chk(l2 == 32'd0, "R3 low wrapped", 64'(l2), 64'd0);
    chk(h3 == 32'd8, "R3 carry with wrap", 64'(h3), 64'd8);

    // R4: counter write ignored while counting
    wr_reg(5'h00, 32'd0);
    rd_reg(5'h00, d);
    chk(d == 32'd3, "R4 write ignored while counting", 64'(d), 64'd3);

    // R10: unmapped offset
    wr_reg(5'h1C, 32'hDEAD_BEEF);
    rd_reg(5'h1C, d); chk(d == 32'd0, "R10 unmapped reads zero", 64'(d), 64'd0);

    // R6 R8 R9: periodic events from a small start
    wr_reg(5'h08, 32'd0);
    wr_reg(5'h00, 32'd0); wr_reg(5'h04, 32'd0);
    wr_reg(5'h10, 32'd12); wr_reg(5'h14, 32'd0);
    wr_reg(5'h18, 32'd5);
    wr_reg(5'h08, 32'hF);
    repeat (40) @(negedge clk);
    rd_reg(5'h0C, d); chk(d == 32'd1, "R6 event flag set", 64'(d), 64'd1);
    chk(irq == 1'b1, "R9 irq with flag and enable", 64'(irq), 64'd1);
    wr_reg(5'h0C, 32'd0);
    rd_reg(5'h0C, d); chk(d == 32'd1, "R7 write zero keeps flag", 64'(d), 64'd1);
    wr_reg(5'h08, 32'h3);
    wr_reg(5'h0C, 32'd1);
    rd_reg(5'h0C, d); chk(d == 32'd0 || m_flag, "R7 clear", 64'(d), 64'(m_flag));

    // constrained random traffic, compare near count
    for (int i = 0; i < 5000; i++) begin
      int unsigned op;
      op = $urandom % 9;
      case (op)
        0, 1: rd_reg(addrs[$urandom % 9], d);
        2: wr_reg(5'h08, {28'd0, 4'($urandom)});
        3: if ($urandom % 4 == 0) wr_reg(5'h04, m_cnt[63:32] + ($urandom % 2));
           else wr_reg(5'h00, ($urandom % 2) ? 32'hFFFF_FFF0 + ($urandom % 16) : $urandom % 40);
        4: wr_reg(5'h10, m_cnt[31:0] + ($urandom % 24));
        5: wr_reg(5'h14, m_cnt[63:32]);
        6: wr_reg(5'h0C, 32'($urandom % 2));
        7: wr_reg(($urandom % 3 == 0) ? 5'h1C : 5'h18, $urandom % 16);
        default: repeat ($urandom % 4 + 1) @(negedge clk);
      endcase
    end

    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule